// File: doc/BRIEF.md
# Indexed-Register Cartridge Bank Mapper

This block turns CPU and PPU address bits into the upper address bits of a cartridge's program ROM and character ROM. Software sets it up with a pair of writes into the lower half of the upper program area. An even-address write chooses which of eight bank registers is to be loaded. The odd-address write that follows supplies the value for that register. The index stays in place, so several value writes in a row all go to the same register.

The CPU side has four 8 KB windows. The two lower windows are switchable, and the upper 16 KB always shows the last two banks of program ROM. The PPU side has eight 1 KB windows. The lower 4 KB is covered by two 2 KB banks and the upper 4 KB by four 1 KB banks. A build-time option drives the top character address bit straight from PPU A12. With that option on, the lower and upper halves of a 128 KB character ROM can each be reached only from their own half of the pattern space.

Top module: `ixmap_top`

## Requirements
- R1: A write with CPU A15..A13 = 100 and A0 = 0 loads data bits [2:0] into the index register.
- R2: A write with CPU A15..A13 = 100 and A0 = 1 stores the data into the register named by the index. The index is left unchanged, so a second value write goes to the same register.
- R3: A write whose CPU A15..A13 is anything other than 100 changes no register and leaves the index as it is.
- R4: After reset all registers and the index are zero, so every switchable window shows bank 0.
- R5: The CPU window code (A14,A13) = 00 gives the low 4 bits of register 6, and code 01 gives the low 4 bits of register 7.
- R6: CPU window code 10 gives program bank 14 and code 11 gives bank 15, the last two 8 KB banks of 128 KB.
- R7: PPU A12..A11 = 00 gives {register 0 bits 5:1, PPU A10}, and A12..A11 = 01 gives {register 1 bits 5:1, PPU A10}. The lowest bit of registers 0 and 1 never appears in the output.
- R8: PPU A12..A10 = 100, 101, 110 and 111 give the 6-bit values of registers 2, 3, 4 and 5.
- R9: Bit 6 of the character bank is 0 in the default build. When A12_TO_TOP = 1 it equals PPU A12.
- R10: Registers 6 and 7 keep only data bits [3:0]. Data bits 5:4 written to them never reach the program bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_hi | input | 3 | CPU address A15..A13 |
| cpu_a0 | input | 1 | CPU address A0 (0 = index write, 1 = value write) |
| cpu_wdata | input | 6 | CPU write data bits 5..0 |
| ppu_hi | input | 3 | PPU address A12..A10 |
| prg_bank | output | 4 | Program ROM A16..A13 |
| chr_bank | output | 7 | Character ROM A16..A10 |

## Verification
The bench places two copies side by side that see the same inputs. One copy uses the default build and the other sets A12_TO_TOP = 1, so the top character bit is checked both when it is held at zero and when it follows PPU A12 in every window. Both copies use the default 16 program banks and 6-bit character registers. This keeps the fixed banks at 14 and 15 and makes the data bits 5:4 that program registers drop visible at the outputs.

// File: rtl/ixmap_pkg.sv
package ixmap_pkg;
  localparam int IDX_W    = 3;
  localparam int NUM_CHR  = 6;
  localparam int NUM_PRG  = 2;
  localparam int PRG_BASE = 6;  // register numbers 6 and 7 are program banks

  // register feeding a given 1 KB PPU window
  function automatic logic [IDX_W-1:0] chr_src(input logic [2:0] win);
    if (!win[2]) chr_src = {2'b00, win[1]};
    else         chr_src = win - 3'd2;
  endfunction
endpackage

// File: rtl/ixmap_regfile.sv
module ixmap_regfile import ixmap_pkg::*; #(
  parameter int CHR_W = 6,
  parameter int PRG_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cpu_we,
  input  logic [2:0]                      cpu_hi,
  input  logic                            cpu_a0,
  input  logic [CHR_W-1:0]                cpu_wdata,
  output logic [NUM_CHR-1:0][CHR_W-1:0]   chr_regs,
  output logic [NUM_PRG-1:0][PRG_W-1:0]   prg_regs
);
  logic [IDX_W-1:0] cur_idx;
  logic             in_win, idx_wr, data_wr;

  assign in_win  = cpu_we && (cpu_hi == 3'b100);
  assign idx_wr  = in_win && !cpu_a0;
  assign data_wr = in_win &&  cpu_a0;

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_idx <= '0;
    else if (idx_wr) cur_idx <= cpu_wdata[IDX_W-1:0];
  end

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr
    always_ff @(posedge clk) begin
      if (!rst_n) chr_regs[i] <= '0;
      else if (data_wr && cur_idx == IDX_W'(i)) chr_regs[i] <= cpu_wdata;
    end
  end

  for (genvar j = 0; j < NUM_PRG; j++) begin : g_prg
    always_ff @(posedge clk) begin
      if (!rst_n) prg_regs[j] <= '0;
      else if (data_wr && cur_idx == IDX_W'(PRG_BASE + j))
        prg_regs[j] <= cpu_wdata[PRG_W-1:0];
    end
  end

  a_r1_index_latch: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> cur_idx == $past(cpu_wdata[IDX_W-1:0]));
  a_r2_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> $stable(cur_idx));
  a_r3_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_hi != 3'b100) |=>
      ($stable(chr_regs) && $stable(prg_regs) && $stable(cur_idx)));
  a_r10_prg_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_idx == IDX_W'(PRG_BASE)) |=>
      prg_regs[0] == $past(cpu_wdata[PRG_W-1:0]));
endmodule

// File: rtl/ixmap_prg_xlate.sv
module ixmap_prg_xlate import ixmap_pkg::*; #(
  parameter int PRG_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    cpu_win,
  input  logic [NUM_PRG-1:0][PRG_W-1:0] prg_regs,
  output logic [PRG_W-1:0]              prg_bank
);
  localparam logic [PRG_W-1:0] LAST = {PRG_W{1'b1}};

  function automatic logic [PRG_W-1:0] pick(input logic [1:0] w,
                                            input logic [PRG_W-1:0] r0,
                                            input logic [PRG_W-1:0] r1);
    case (w)
      2'b00:   pick = r0;
      2'b01:   pick = r1;
      2'b10:   pick = LAST - 1'b1;
      default: pick = LAST;
    endcase
  endfunction

  assign prg_bank = pick(cpu_win, prg_regs[0], prg_regs[1]);

  a_r6_fixed_upper: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_win[1] |-> prg_bank[PRG_W-1:1] == LAST[PRG_W-1:1] && prg_bank[0] == cpu_win[0]);
endmodule

// File: rtl/ixmap_chr_xlate.sv
module ixmap_chr_xlate import ixmap_pkg::*; #(
  parameter int CHR_W      = 6,
  parameter bit A12_TO_TOP = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    ppu_hi,
  input  logic [NUM_CHR-1:0][CHR_W-1:0] chr_regs,
  output logic [CHR_W:0]                chr_bank
);
  logic [CHR_W-1:0] low;
  logic             top;

  function automatic logic [CHR_W-1:0] lower(input logic [2:0] w,
                                             input logic [CHR_W-1:0] r);
    if (!w[2]) lower = {r[CHR_W-1:1], w[0]};  // 2 KB bank: A10 passes through
    else       lower = r;
  endfunction

  assign low = lower(ppu_hi, chr_regs[chr_src(ppu_hi)]);

  if (A12_TO_TOP) begin : g_a12
    assign top = ppu_hi[2];
    a_r9_top_follows_a12: assert property (@(posedge clk) disable iff (!rst_n)
      chr_bank[CHR_W] == ppu_hi[2]);
  end else begin : g_flat
    assign top = 1'b0;
    a_r9_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      chr_bank[CHR_W] == 1'b0);
  end

  assign chr_bank = {top, low};

  a_r7_a10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_hi[2] |-> chr_bank[0] == ppu_hi[0]);
endmodule

// File: rtl/ixmap_top.sv
module ixmap_top import ixmap_pkg::*; #(
  parameter int PRG_BANKS  = 16,
  parameter int CHR_BANKS  = 64,
  parameter bit A12_TO_TOP = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_we,
  input  logic [2:0]                    cpu_hi,
  input  logic                          cpu_a0,
  input  logic [$clog2(CHR_BANKS)-1:0]  cpu_wdata,
  input  logic [2:0]                    ppu_hi,
  output logic [$clog2(PRG_BANKS)-1:0]  prg_bank,
  output logic [$clog2(CHR_BANKS):0]    chr_bank
);
  localparam int PRG_W = $clog2(PRG_BANKS);
  localparam int CHR_W = $clog2(CHR_BANKS);

  logic [NUM_CHR-1:0][CHR_W-1:0] chr_regs;
  logic [NUM_PRG-1:0][PRG_W-1:0] prg_regs;

  ixmap_regfile #(.CHR_W(CHR_W), .PRG_W(PRG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_hi(cpu_hi),
    .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata),
    .chr_regs(chr_regs), .prg_regs(prg_regs));

  ixmap_prg_xlate #(.PRG_W(PRG_W)) u_prg (
    .clk(clk), .rst_n(rst_n), .cpu_win(cpu_hi[1:0]),
    .prg_regs(prg_regs), .prg_bank(prg_bank));

  ixmap_chr_xlate #(.CHR_W(CHR_W), .A12_TO_TOP(A12_TO_TOP)) u_chr (
    .clk(clk), .rst_n(rst_n), .ppu_hi(ppu_hi),
    .chr_regs(chr_regs), .chr_bank(chr_bank));
endmodule

// File: tb/ixmap_top_test.sv
module ixmap_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_we = 1'b0;
  logic [2:0] cpu_hi = 3'b000;
  logic       cpu_a0 = 1'b0;
  logic [5:0] cpu_wdata = '0;
  logic [2:0] ppu_hi = 3'b000;
  logic [3:0] prg_bank, prg_bank_v;
  logic [6:0] chr_bank, chr_bank_v;

  int total = 0;
  int bad = 0;

  logic [5:0] m_reg [8];
  logic [2:0] m_idx;

  always #10 clk = ~clk;  // 50 MHz

  ixmap_top uut (.clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_hi(cpu_hi),
    .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata), .ppu_hi(ppu_hi),
    .prg_bank(prg_bank), .chr_bank(chr_bank));
  ixmap_top #(.A12_TO_TOP(1'b1)) uut_v (.clk(clk), .rst_n(rst_n), .cpu_we(cpu_we),
    .cpu_hi(cpu_hi), .cpu_a0(cpu_a0), .cpu_wdata(cpu_wdata), .ppu_hi(ppu_hi),
    .prg_bank(prg_bank_v), .chr_bank(chr_bank_v));

  function automatic logic [3:0] exp_prg(input logic [1:0] w);
    if (w == 2'd0)      return m_reg[6][3:0];
    else if (w == 2'd1) return m_reg[7][3:0];
    else                return 4'd12 + 4'(w);
  endfunction

  function automatic logic [6:0] exp_chr(input logic [2:0] w, input bit var_a12);
    logic top;
    top = var_a12 ? w[2] : 1'b0;
    if (w < 3'd2)      return {top, m_reg[0][5:1], w[0]};
    else if (w < 3'd4) return {top, m_reg[1][5:1], w[0]};
    else               return {top, m_reg[int'(w) - 2]};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] hi, input logic a0, input logic [5:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_hi = hi; cpu_a0 = a0; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    if (hi == 3'b100) begin
      if (!a0) m_idx = d[2:0];
      else     m_reg[m_idx] = (m_idx >= 3'd6) ? {2'b00, d[3:0]} : d;
    end
  endtask

  task automatic probe_all(input string req);
    for (int w = 0; w < 4; w++) begin
      cpu_hi = 3'(4 + w); #1;
      check(req, {3'b0, prg_bank}, {3'b0, exp_prg(2'(w))});
    end
    for (int w = 0; w < 8; w++) begin
      ppu_hi = 3'(w); #1;
      check(req, chr_bank, exp_chr(3'(w), 1'b0));
      check("R9", chr_bank_v, exp_chr(3'(w), 1'b1));
    end
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe_all("R4");

    // R1/R2: load every register, then a second value write to the same index
    for (int r = 0; r < 8; r++) begin
      wr(3'b100, 1'b0, 6'(r));
      wr(3'b100, 1'b1, 6'(7 * r + 9));
    end
    probe_all("R5 R7 R8");
    wr(3'b100, 1'b0, 6'd6);
    wr(3'b100, 1'b1, 6'h35);          // R10: bits 5:4 dropped
    wr(3'b100, 1'b1, 6'h3a);          // R2: index still 6
    cpu_hi = 3'b100; #1;
    check("R2 R10", {3'b0, prg_bank}, 7'h0a);
    probe_all("R6");

    // R3: writes above the register window change nothing
    for (int h = 5; h < 8; h++) begin
      wr(3'(h), 1'b0, 6'd7);
      wr(3'(h), 1'b1, 6'h3f);
    end
    wr(3'b000, 1'b1, 6'h3f);
    probe_all("R3");
    wr(3'b100, 1'b1, 6'h21);          // index still 6 after ignored writes
    probe_all("R3 R1");

    // R7: odd value in register 0 loses its low bit
    wr(3'b100, 1'b0, 6'd0);
    wr(3'b100, 1'b1, 6'h3f);
    ppu_hi = 3'b000; #1;
    check("R7", chr_bank, 7'h3e);
    ppu_hi = 3'b001; #1;
    check("R7", chr_bank, 7'h3f);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [2:0] h;
      h = ($urandom % 4 == 0) ? 3'($urandom) : 3'b100;
      wr(h, 1'($urandom), 6'($urandom));
      cpu_hi = 3'(4 + $urandom % 4); #1;
      check("R5 R6", {3'b0, prg_bank}, {3'b0, exp_prg(cpu_hi[1:0])});
      ppu_hi = 3'($urandom); #1;
      check("R7 R8", chr_bank, exp_chr(ppu_hi, 1'b0));
      check("R9", chr_bank_v, exp_chr(ppu_hi, 1'b1));
    end

    // R4 again: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_idx = '0;
    probe_all("R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule